// File: doc/BRIEF.md
# USB dual-role port role selector

This block decides, cycle by cycle, whether a dual-role USB port runs as a host, as a peripheral, or as neither. It watches the cable identification pin and the session-valid (VBUS) indication. Both pass through synchronizers. Each pin change is recorded in a sticky change flag, and the flag gates when the latched input value is allowed to move. A small role machine turns the latched values, together with two "function present" inputs, into a host enable, a peripheral enable and a one-cycle controller reset request on every role exit.

Software works through one 32-bit status word. It reads the latched inputs, the change flags and the two enables there. It clears flags by writing ones and sets the enables. On boards whose pins are strapped, software can instead force the latched inputs with a role command. Each command is accepted only from the states where it makes sense. A parameter fixes the port to dual-role, host-only (ID held low) or peripheral-only (ID held high).

Top module: `otg_role_fsm`

## Requirements
- R1: While reset is held and in the single sampling cycle that follows it, no role is enabled, `ctrl_reset` is high and `csr_rdata` reads 0x0000_0100 (latched ID high, everything else zero) in the dual-role configuration; the next cycle the machine is idle.
- R2: A level change on either pin, after two synchronizer flops, sets its change flag (ID flag bit 16, session flag bit 19) whatever the enables hold; writing 1 to a flag bit clears it, writing 0 leaves it set.
- R3: A latched input (ID at bit 8, session at bit 11) follows its synchronized pin only while its change flag and its enable (ID enable bit 24, session enable bit 27) are both set; a pending enabled ID change blocks the session update until the ID flag is cleared.
- R4: From idle the machine enters host (role code 2) when latched ID is low and `host_avail` is high; failing that it enters peripheral (role code 1) when latched session is high and `periph_avail` is high; role code 0 means none.
- R5: Entering host clears the session enable bit 27.
- R6: Peripheral is left when latched session is low or latched ID is low, and host is left when latched ID is high; each exit raises `ctrl_reset` for exactly one cycle, goes to idle and re-evaluates on the next cycle.
- R7: `irq` is high exactly when some change flag and its enable are both set.
- R8: Role commands on `force_cmd` (0 none, 1 peripheral, 2 host, 3 ignored) apply only from legal states: none from host or peripheral sets ID high and session low; peripheral from idle or host sets both high; host from idle or peripheral sets ID low; otherwise the command is ignored.
- R9: With `ROLE_CFG` 1 (host-only) latched ID is always low, and with `ROLE_CFG` 2 (peripheral-only) it is always high, whatever the ID pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_pin | input | 1 | Raw cable identification pin, asynchronous |
| sess_pin | input | 1 | Raw session-valid indication, asynchronous |
| host_avail | input | 1 | A host function is present |
| periph_avail | input | 1 | A peripheral function is present |
| csr_wr | input | 1 | Write strobe for the status word |
| csr_wdata | input | 32 | Write data: flag bits clear on 1, enable bits load |
| csr_rdata | output | 32 | Status word: latched inputs, flags, enables |
| force_vld | input | 1 | Role command strobe |
| force_cmd | input | 2 | Role command code |
| host_en | output | 1 | Port acts as host |
| periph_en | output | 1 | Port acts as peripheral |
| ctrl_reset | output | 1 | Controller reset request |
| role | output | 2 | Current role code |
| irq | output | 1 | Enabled change interrupt |

## Verification
The embedded properties watch, on every cycle, that a role is only entered from idle with its inputs satisfied, that host entry drops the session enable, that every role exit is preceded by a reset request, that a pin edge always sets its flag, and that the session latch holds still while an enabled ID change is pending. The bench's scenarios show the end-to-end behaviour: the delay from pin to role, the host-over-peripheral priority under many pin and function patterns, selective write-one clearing, the legality table of role commands, and the forced ID values of the two single-role configurations.

// File: rtl/otg_role_fsm.sv
module otg_role_fsm #(
  parameter int ROLE_CFG    = 0,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 32,
  parameter int ID_BIT      = 8,
  parameter int SV_BIT      = 11,
  parameter int ID_CHG_BIT  = 16,
  parameter int SV_CHG_BIT  = 19,
  parameter int ID_IE_BIT   = 24,
  parameter int SV_IE_BIT   = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_pin,
  input  logic             sess_pin,
  input  logic             host_avail,
  input  logic             periph_avail,
  input  logic             csr_wr,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata,
  input  logic             force_vld,
  input  logic [1:0]       force_cmd,
  output logic             host_en,
  output logic             periph_en,
  output logic             ctrl_reset,
  output logic [1:0]       role,
  output logic             irq
);

  localparam bit FORCE_ID  = (ROLE_CFG != 0);
  localparam bit FORCE_VAL = (ROLE_CFG == 2);
  localparam bit ID_RST    = FORCE_ID ? FORCE_VAL : 1'b1;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_PER  = 2'd1;
  localparam logic [1:0] CMD_HOST = 2'd2;

  typedef enum logic [1:0] {ST_UNDEF, ST_IDLE, ST_PERIPH, ST_HOST} st_t;
  st_t st, st_nx;

  logic [SYNC_STAGES-1:0] id_sync, sv_sync;
  logic id_s, sv_s, id_d, sv_d, id_edge, sv_edge;
  logic id_l, sv_l, id_chg, sv_chg, id_ie, sv_ie;
  logic go_host, go_per, per_exit, host_exit, ovr_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      id_sync <= '1;
      sv_sync <= '0;
      id_d    <= 1'b1;
      sv_d    <= 1'b0;
    end else begin
      id_sync <= {id_sync[SYNC_STAGES-2:0], id_pin};
      sv_sync <= {sv_sync[SYNC_STAGES-2:0], sess_pin};
      id_d    <= id_s;
      sv_d    <= sv_s;
    end

  assign id_s    = id_sync[SYNC_STAGES-1];
  assign sv_s    = sv_sync[SYNC_STAGES-1];
  assign id_edge = id_s ^ id_d;
  assign sv_edge = sv_s ^ sv_d;

  assign go_host   = !id_l && host_avail;
  assign go_per    = sv_l && periph_avail;
  assign per_exit  = !sv_l || !id_l;
  assign host_exit = id_l;

  always_comb begin
    ovr_ok = 1'b0;
    if (force_vld)
      case (force_cmd)
        CMD_NONE: ovr_ok = (st == ST_HOST) || (st == ST_PERIPH);
        CMD_PER:  ovr_ok = (st == ST_IDLE) || (st == ST_HOST);
        CMD_HOST: ovr_ok = (st == ST_IDLE) || (st == ST_PERIPH);
        default:  ovr_ok = 1'b0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      id_l <= ID_RST;
      sv_l <= 1'b0;
    end else begin
      if (st == ST_UNDEF) begin
        id_l <= id_s;
        sv_l <= sv_s;
      end else if (ovr_ok) begin
        case (force_cmd)
          CMD_NONE: begin id_l <= 1'b1; sv_l <= 1'b0; end
          CMD_PER:  begin id_l <= 1'b1; sv_l <= 1'b1; end
          default:  id_l <= 1'b0;
        endcase
      end else if (id_chg && id_ie) begin
        id_l <= id_s;
      end else if (sv_chg && sv_ie) begin
        sv_l <= sv_s;
      end
      if (FORCE_ID) id_l <= FORCE_VAL;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      id_chg <= 1'b0;
      sv_chg <= 1'b0;
      id_ie  <= 1'b0;
      sv_ie  <= 1'b0;
    end else begin
      id_chg <= id_edge || (id_chg && !(csr_wr && csr_wdata[ID_CHG_BIT]));
      sv_chg <= sv_edge || (sv_chg && !(csr_wr && csr_wdata[SV_CHG_BIT]));
      if (csr_wr) id_ie <= csr_wdata[ID_IE_BIT];
      if (st == ST_IDLE && go_host) sv_ie <= 1'b0;
      else if (csr_wr)              sv_ie <= csr_wdata[SV_IE_BIT];
    end

  always_comb begin
    st_nx = st;
    case (st)
      ST_UNDEF:  st_nx = ST_IDLE;
      ST_IDLE:   if (go_host) st_nx = ST_HOST;
                 else if (go_per) st_nx = ST_PERIPH;
      ST_PERIPH: if (per_exit) st_nx = ST_IDLE;
      ST_HOST:   if (host_exit) st_nx = ST_IDLE;
      default:   st_nx = ST_UNDEF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_UNDEF;
    else        st <= st_nx;

  assign host_en    = (st == ST_HOST);
  assign periph_en  = (st == ST_PERIPH);
  assign role       = host_en ? 2'd2 : (periph_en ? 2'd1 : 2'd0);
  assign ctrl_reset = (st == ST_UNDEF) || (periph_en && per_exit) || (host_en && host_exit);
  assign irq        = (id_chg && id_ie) || (sv_chg && sv_ie);

  always_comb begin
    csr_rdata             = '0;
    csr_rdata[ID_BIT]     = id_l;
    csr_rdata[SV_BIT]     = sv_l;
    csr_rdata[ID_CHG_BIT] = id_chg;
    csr_rdata[SV_CHG_BIT] = sv_chg;
    csr_rdata[ID_IE_BIT]  = id_ie;
    csr_rdata[SV_IE_BIT]  = sv_ie;
  end

  a_r2_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    id_edge |=> id_chg);

  a_r3_sv_waits_for_id: assert property (@(posedge clk) disable iff (!rst_n)
    (id_chg && id_ie && !ovr_ok && st != ST_UNDEF) |=> $stable(sv_l));

  a_r4_host_entry_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_en) |-> ($past(host_avail) && !$past(id_l)));

  a_r5_host_drops_sv_ie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_en) |-> !sv_ie);

  a_r6_host_exit_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_en) |-> $past(ctrl_reset));

  a_r6_periph_exit_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_en) |-> $past(ctrl_reset));

  generate
    if (ROLE_CFG == 1) begin : g_host_only
      a_r9_no_periph: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en);
    end else if (ROLE_CFG == 2) begin : g_periph_only
      a_r9_no_host: assert property (@(posedge clk) disable iff (!rst_n)
        !host_en);
    end
  endgenerate

endmodule

// File: tb/otg_role_fsm_bench.sv
module otg_role_fsm_bench;

  localparam logic [31:0] EN  = 32'h0900_0000;
  localparam logic [31:0] CLR = 32'h0009_0000;
  localparam int NV = 12;
  // {id_pin, sess_pin, host_avail, periph_avail, role[1:0]}
  localparam logic [5:0] VEC [NV] = '{
    6'b1111_01, 6'b0111_10, 6'b0011_10, 6'b1011_00,
    6'b1111_01, 6'b1011_00, 6'b0001_00, 6'b0011_10,
    6'b1011_00, 6'b1110_00, 6'b1111_01, 6'b1011_00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic id_pin = 1'b1, sess_pin = 1'b0, host_avail = 1'b1, periph_avail = 1'b1;
  logic csr_wr = 1'b0, force_vld = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [1:0]  force_cmd = '0;
  logic [31:0] rdata, rdata_h, rdata_p;
  logic host_en, periph_en, ctrl_reset, irq;
  logic host_en_h, periph_en_h, ctrl_reset_h, irq_h;
  logic host_en_p, periph_en_p, ctrl_reset_p, irq_p;
  logic [1:0] role, role_h, role_p;
  int n_chk = 0, n_bad = 0, pulses = 0;

  always #5 clk = ~clk;

  otg_role_fsm u_otg_role_fsm (
    .clk, .rst_n, .id_pin, .sess_pin, .host_avail, .periph_avail,
    .csr_wr, .csr_wdata, .csr_rdata(rdata), .force_vld, .force_cmd,
    .host_en, .periph_en, .ctrl_reset, .role, .irq);

  otg_role_fsm #(.ROLE_CFG(1)) u_host_only (
    .clk, .rst_n, .id_pin, .sess_pin, .host_avail, .periph_avail,
    .csr_wr, .csr_wdata, .csr_rdata(rdata_h), .force_vld, .force_cmd,
    .host_en(host_en_h), .periph_en(periph_en_h), .ctrl_reset(ctrl_reset_h),
    .role(role_h), .irq(irq_h));

  otg_role_fsm #(.ROLE_CFG(2)) u_periph_only (
    .clk, .rst_n, .id_pin, .sess_pin, .host_avail, .periph_avail,
    .csr_wr, .csr_wdata, .csr_rdata(rdata_p), .force_vld, .force_cmd,
    .host_en(host_en_p), .periph_en(periph_en_p), .ctrl_reset(ctrl_reset_p),
    .role(role_p), .irq(irq_p));

  always @(negedge clk) if (rst_n && ctrl_reset) pulses++;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    csr_wr = 1'b1; csr_wdata = d;
    cyc(1);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic frc(input logic [1:0] c);
    force_vld = 1'b1; force_cmd = c;
    cyc(1);
    force_vld = 1'b0; force_cmd = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1 role", {30'd0, role}, 32'd0);
    chk("R1 enables", {30'd0, host_en, periph_en}, 32'd0);
    chk("R1 reset request", {31'd0, ctrl_reset}, 32'd1);
    chk("R1 status", rdata, 32'h0000_0100);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 idle after sampling", {31'd0, ctrl_reset}, 32'd0);
    cyc(2);

    // R3 gating: flag without enable leaves the latch alone
    id_pin = 1'b0;
    cyc(8);
    chk("R3 gated latch", rdata, 32'h0001_0100);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    chk("R3 gated role", {30'd0, role}, 32'd0);
    wr(EN);
    cyc(3);
    chk("R4 host entry", {30'd0, role}, 32'd2);
    chk("R5 session enable cleared", rdata, 32'h0101_0000);
    chk("R7 irq raised", {31'd0, irq}, 32'd1);
    wr(EN | CLR);
    chk("R2 flags cleared", rdata, 32'h0900_0000);
    chk("R7 irq after clear", {31'd0, irq}, 32'd0);

    pulses = 0;
    id_pin = 1'b1;
    cyc(8);
    chk("R6 one reset pulse on host exit", pulses, 32'd1);
    chk("R6 back to idle", {30'd0, role}, 32'd0);
    wr(EN | CLR);

    for (int i = 0; i < NV; i++) begin
      id_pin = VEC[i][5]; sess_pin = VEC[i][4];
      host_avail = VEC[i][3]; periph_avail = VEC[i][2];
      cyc(6);
      wr(EN | CLR);
      cyc(6);
      chk($sformatf("R4 R6 vector %0d role", i), {30'd0, role}, {30'd0, VEC[i][1:0]});
      chk($sformatf("R4 vector %0d enables", i), {30'd0, host_en, periph_en},
          {30'd0, VEC[i][1:0] == 2'd2, VEC[i][1:0] == 2'd1});
    end

    chk("R9 host-only forces host", {30'd0, role_h}, 32'd2);
    chk("R9 host-only latched ID", {31'd0, rdata_h[8]}, 32'd0);
    chk("R9 periph-only idle", {30'd0, role_p}, 32'd0);
    sess_pin = 1'b1;
    cyc(6);
    wr(EN | CLR);
    cyc(6);
    chk("R4 main peripheral", {30'd0, role}, 32'd1);
    chk("R9 host-only stays host", {30'd0, role_h}, 32'd2);
    chk("R9 periph-only peripheral", {30'd0, role_p}, 32'd1);
    chk("R9 periph-only latched ID", {31'd0, rdata_p[8]}, 32'd1);

    // R3 priority: both pins move, session waits for the ID flag
    id_pin = 1'b0; sess_pin = 1'b0;
    cyc(8);
    chk("R3 ID first, session held", rdata, 32'h0109_0800);
    chk("R4 host after both move", {30'd0, role}, 32'd2);
    wr(32'h0901_0000);
    cyc(3);
    chk("R2 selective clear, R3 session follows", rdata, 32'h0908_0000);
    wr(EN | CLR);

    wr(CLR);
    chk("R8 start in host", {30'd0, role}, 32'd2);
    frc(2'd1);
    cyc(2);
    chk("R8 peripheral from host", {30'd0, role}, 32'd1);
    chk("R8 peripheral sets both", rdata, 32'h0000_0900);
    frc(2'd2);
    cyc(2);
    chk("R8 host from peripheral", {30'd0, role}, 32'd2);
    chk("R8 host clears ID", rdata, 32'h0000_0800);
    frc(2'd0);
    cyc(2);
    chk("R8 none from host", {30'd0, role}, 32'd0);
    chk("R8 none values", rdata, 32'h0000_0100);
    periph_avail = 1'b0;
    frc(2'd1);
    cyc(2);
    chk("R8 peripheral from idle, no function", {30'd0, role}, 32'd0);
    chk("R8 peripheral from idle values", rdata, 32'h0000_0900);
    frc(2'd0);
    cyc(2);
    chk("R8 none ignored in idle", rdata, 32'h0000_0900);
    frc(2'd3);
    cyc(2);
    chk("R8 reserved code ignored", rdata, 32'h0000_0900);
    periph_avail = 1'b1;
    cyc(2);
    chk("R4 peripheral once function appears", {30'd0, role}, 32'd1);

    finish_run();
  end

endmodule